// File: doc/BRIEF.md
# Dual-Overflow Watchdog Timer

This block is a watchdog peripheral with a small register bus and one counting clock. Software writes a 12-bit timeout value, may clear the elapsed count, and then sets the enable bit. Once enabled, the timer counts in steps of 2^PRE_W clock cycles. It completes an overflow period when the step count has passed the timeout value. The first overflow raises an interrupt. If a second overflow follows with no refresh in between, the reset output is asserted. A refresh write clears the elapsed count and the interrupt. It takes effect on the next edge, and the new period starts from zero.

Writes to every register except the refresh register pass through a fixed settling pipeline. They are committed SETTLE cycles after the write. Reads return the committed values. A second path lets software ask for a reset at once. When the parity-error routing bit is 0, a write of 1 to the force register raises the reset output. The block has four states, named here with their transitions:

- ST_IDLE: not enabled. It moves to ST_RUN when the enable commits.
- ST_RUN: counting the first period. A refresh keeps it in ST_RUN. An overflow moves it to ST_WARN.
- ST_WARN: the interrupt is pending. A refresh returns it to ST_RUN. An overflow moves it to ST_BITE.
- ST_BITE: the reset output is held until the module reset.

A forced parity error moves any state to ST_BITE. When a refresh and an overflow occur on the same edge, the refresh wins.

Top module: `wdog_dual_ovf`

## Requirements
- R1: After rst_n is released, the registers read as follows: control (0x00) reads 0, timeout (0x04) reads 0, elapsed (0x08) reads 0, interrupt (0x0C) reads 0, and parity routing (0x10) reads 1. Both irq_o and wdt_rst_o are 0.
- R2: The timeout register at 0x04 holds only bits 31:20. Bits 19:0 are discarded on write and read back as 0.
- R3: A write to any offset other than 0x0C is committed SETTLE (6) cycles after the edge that captures it. Up to that commit edge, a read returns the old value.
- R4: Setting bit 0 of control (0x00) starts counting. When the enable commits on edge S, irq_o rises on edge S + 2^PRE_W*(T+1), where T is the timeout field.
- R5: A second overflow period with no refresh asserts wdt_rst_o. Once asserted, wdt_rst_o stays at 1 until rst_n, and a refresh cannot clear it.
- R6: A write of 1 to bit 0 of 0x0C clears irq_o and the elapsed count on the capturing edge and starts a new full period. A write with bit 0 at 0 has no effect.
- R7: Once the watchdog is enabled, a write of 0 to control does not stop it, and control still reads 1.
- R8: Reading elapsed (0x08) returns the number of completed 2^PRE_W-cycle steps in the current period. A committed write of 0 to 0x08 restarts the count from zero, and the period is measured from the commit edge.
- R9: When the parity routing bit (0x10 bit 0) is 0, a committed write of 1 to bit 0 of the force register (0x14) asserts wdt_rst_o on the commit edge, even when the watchdog is not enabled. When the routing bit is 1, such a write has no effect.
- R10: The force register (0x14) and the unused offsets 0x18 and 0x1C read as 0, and writes to them change no readable register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Counting and bus clock |
| rst_n | input | 1 | Active-low module reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW | Write byte offset |
| wr_data | input | DW | Write data |
| rd_addr | input | AW | Read byte offset |
| rd_data | output | DW | Committed read data (combinational) |
| irq_o | output | 1 | First-overflow interrupt |
| wdt_rst_o | output | 1 | Watchdog reset request |

## Verification
The readback path is driven with timeout words whose low 20 bits are all ones or all zeros, with both values of the routing bit and with unused offsets. This separates masking, decoding and the ignoring of writes. The timing of each commit is probed one cycle before and one cycle after the settle edge. The counting function runs under four patterns, each checked on the exact edge: no refresh, a single refresh, a refresh with bit 0 clear, and a late restart of the elapsed count. Together they separate the first-overflow point, the restart after a refresh, the ignored refresh, the moved period and the second-overflow reset. The forced-parity path is tried with the watchdog disabled, so a reset there can only come from that path.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RUN,
        ST_WARN,
        ST_BITE
    } wd_state_e;

    localparam logic [7:0] OFS_CTRL    = 8'h00;
    localparam logic [7:0] OFS_TOUT    = 8'h04;
    localparam logic [7:0] OFS_ELAPSED = 8'h08;
    localparam logic [7:0] OFS_INT     = 8'h0C;
    localparam logic [7:0] OFS_PEROUTE = 8'h10;
    localparam logic [7:0] OFS_FORCE   = 8'h14;

endpackage

// File: rtl/wdog_settle.sv
module wdog_settle #(
    parameter int AW    = 5,
    parameter int DW    = 32,
    parameter int DEPTH = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_vld,
    input  logic [AW-1:0] in_addr,
    input  logic [DW-1:0] in_data,
    output logic          out_vld,
    output logic [AW-1:0] out_addr,
    output logic [DW-1:0] out_data
);

    logic [DEPTH-1:0] vld_q;
    logic [AW-1:0]    addr_q [DEPTH];
    logic [DW-1:0]    data_q [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_stage
        if (i == 0) begin : g_head
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    vld_q[i]  <= 1'b0;
                    addr_q[i] <= '0;
                    data_q[i] <= '0;
                end else begin
                    vld_q[i]  <= in_vld;
                    addr_q[i] <= in_addr;
                    data_q[i] <= in_data;
                end
            end
        end else begin : g_body
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    vld_q[i]  <= 1'b0;
                    addr_q[i] <= '0;
                    data_q[i] <= '0;
                end else begin
                    vld_q[i]  <= vld_q[i-1];
                    addr_q[i] <= addr_q[i-1];
                    data_q[i] <= data_q[i-1];
                end
            end
        end
    end

    assign out_vld  = vld_q[DEPTH-1];
    assign out_addr = addr_q[DEPTH-1];
    assign out_data = data_q[DEPTH-1];

endmodule

// File: rtl/wdog_regs.sv
module wdog_regs
    import wdog_pkg::*;
#(
    parameter int AW = 5,
    parameter int DW = 32,
    parameter int TW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cm_vld,
    input  logic [AW-1:0] cm_addr,
    input  logic [DW-1:0] cm_data,
    input  logic [AW-1:0] rd_addr,
    input  logic [TW-1:0] step_i,
    input  logic          irq_i,
    output logic [DW-1:0] rd_data,
    output logic          en_o,
    output logic [TW-1:0] tout_o,
    output logic          cnt_clr_o,
    output logic          force_o
);

    localparam int TSHIFT = DW - TW;

    logic          en_q;
    logic [TW-1:0] tout_q;
    logic          peroute_q;
    logic          hit_ctrl, hit_tout, hit_elap, hit_route, hit_force;

    always_comb begin
        hit_ctrl  = cm_vld && (cm_addr == OFS_CTRL[AW-1:0]);
        hit_tout  = cm_vld && (cm_addr == OFS_TOUT[AW-1:0]);
        hit_elap  = cm_vld && (cm_addr == OFS_ELAPSED[AW-1:0]);
        hit_route = cm_vld && (cm_addr == OFS_PEROUTE[AW-1:0]);
        hit_force = cm_vld && (cm_addr == OFS_FORCE[AW-1:0]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q      <= 1'b0;
            tout_q    <= '0;
            peroute_q <= 1'b1;
        end else begin
            if (hit_ctrl && cm_data[0]) en_q <= 1'b1;
            if (hit_tout)               tout_q <= cm_data[DW-1 -: TW];
            if (hit_route)              peroute_q <= cm_data[0];
        end
    end

    always_comb begin
        en_o      = en_q || (hit_ctrl && cm_data[0]);
        tout_o    = tout_q;
        cnt_clr_o = hit_elap && (cm_data == '0);
        force_o   = hit_force && cm_data[0] && !peroute_q;
    end

    always_comb begin
        rd_data = '0;
        unique case (rd_addr)
            OFS_CTRL[AW-1:0]:    rd_data[0] = en_q;
            OFS_TOUT[AW-1:0]:    rd_data = {tout_q, {TSHIFT{1'b0}}};
            OFS_ELAPSED[AW-1:0]: rd_data[TW-1:0] = step_i;
            OFS_INT[AW-1:0]:     rd_data[0] = irq_i;
            OFS_PEROUTE[AW-1:0]: rd_data[0] = peroute_q;
            default:             rd_data = '0;
        endcase
    end

    p_enable_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        en_q |=> en_q);

endmodule

// File: rtl/wdog_core.sv
module wdog_core
    import wdog_pkg::*;
#(
    parameter int TW    = 12,
    parameter int PRE_W = 20
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en_i,
    input  logic [TW-1:0] tout_i,
    input  logic          refresh_i,
    input  logic          cnt_clr_i,
    input  logic          force_i,
    output logic [TW-1:0] step_o,
    output logic          irq_o,
    output logic          bite_o
);

    wd_state_e        state_q, state_d;
    logic [PRE_W-1:0] pre_q;
    logic [TW-1:0]    step_q;
    logic             counting, ovf_hit;

    always_comb begin
        counting = (state_q == ST_RUN) || (state_q == ST_WARN);
        ovf_hit  = counting && (&pre_q) && (step_q == tout_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (force_i)   state_d = ST_BITE;
                else if (en_i) state_d = ST_RUN;
            end
            ST_RUN: begin
                if (force_i)        state_d = ST_BITE;
                else if (refresh_i) state_d = ST_RUN;
                else if (ovf_hit)   state_d = ST_WARN;
            end
            ST_WARN: begin
                if (force_i)        state_d = ST_BITE;
                else if (refresh_i) state_d = ST_RUN;
                else if (ovf_hit)   state_d = ST_BITE;
            end
            ST_BITE: state_d = ST_BITE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q  <= '0;
            step_q <= '0;
        end else if (!counting || refresh_i || cnt_clr_i || ovf_hit) begin
            pre_q  <= '0;
            step_q <= '0;
        end else begin
            pre_q <= pre_q + 1'b1;
            if (&pre_q) step_q <= step_q + 1'b1;
        end
    end

    always_comb begin
        irq_o  = (state_q == ST_WARN);
        bite_o = (state_q == ST_BITE);
        step_o = step_q;
    end

    p_warn_entry_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state_q == ST_WARN) |-> $past(ovf_hit));

    p_bite_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bite_o) |-> ($past(state_q == ST_WARN) || $past(force_i)));

    p_bite_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_BITE) |=> (state_q == ST_BITE));

    p_refresh_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (refresh_i && counting && !force_i) |=> (step_q == '0 && state_q == ST_RUN));

endmodule

// File: rtl/wdog_dual_ovf.sv
module wdog_dual_ovf
    import wdog_pkg::*;
#(
    parameter int AW     = 5,
    parameter int DW     = 32,
    parameter int TW     = 12,
    parameter int PRE_W  = 20,
    parameter int SETTLE = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data,
    output logic          irq_o,
    output logic          wdt_rst_o
);

    logic          is_int, refresh, pipe_in;
    logic          cm_vld;
    logic [AW-1:0] cm_addr;
    logic [DW-1:0] cm_data;
    logic          en, cnt_clr, force_pe, irq, bite;
    logic [TW-1:0] tout, step;

    always_comb begin
        is_int  = (wr_addr == OFS_INT[AW-1:0]);
        refresh = wr_en && is_int && wr_data[0];
        pipe_in = wr_en && !is_int;
    end

    wdog_settle #(.AW(AW), .DW(DW), .DEPTH(SETTLE)) u_settle (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_vld   (pipe_in),
        .in_addr  (wr_addr),
        .in_data  (wr_data),
        .out_vld  (cm_vld),
        .out_addr (cm_addr),
        .out_data (cm_data)
    );

    wdog_regs #(.AW(AW), .DW(DW), .TW(TW)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cm_vld    (cm_vld),
        .cm_addr   (cm_addr),
        .cm_data   (cm_data),
        .rd_addr   (rd_addr),
        .step_i    (step),
        .irq_i     (irq),
        .rd_data   (rd_data),
        .en_o      (en),
        .tout_o    (tout),
        .cnt_clr_o (cnt_clr),
        .force_o   (force_pe)
    );

    wdog_core #(.TW(TW), .PRE_W(PRE_W)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .en_i      (en),
        .tout_i    (tout),
        .refresh_i (refresh),
        .cnt_clr_i (cnt_clr),
        .force_i   (force_pe),
        .step_o    (step),
        .irq_o     (irq),
        .bite_o    (bite)
    );

    assign irq_o     = irq;
    assign wdt_rst_o = bite;

endmodule

// File: tb/wdog_dual_ovf_tb.sv
module wdog_dual_ovf_tb;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 5;
    localparam int DW = 32;
    localparam int NV = 8;

    localparam logic [AW-1:0] A_CTRL = 5'h00, A_TOUT = 5'h04, A_ELAP = 5'h08,
                              A_INT = 5'h0C, A_ROUTE = 5'h10, A_FORCE = 5'h14;

    localparam logic [AW-1:0] V_ADDR [NV] = '{5'h04, 5'h04, 5'h04, 5'h10,
                                             5'h10, 5'h14, 5'h18, 5'h1C};
    localparam logic [DW-1:0] V_DATA [NV] = '{32'hABCFFFFF, 32'h000FFFFF, 32'hFFF00000, 32'h0,
                                             32'hFFFFFFFF, 32'h1, 32'hFFFFFFFF, 32'h12345678};
    localparam logic [DW-1:0] V_EXP  [NV] = '{32'hABC00000, 32'h0, 32'hFFF00000, 32'h0,
                                             32'h1, 32'h0, 32'h0, 32'h0};

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic [AW-1:0] rd_addr = '0;
    logic [DW-1:0] rd_data;
    logic          irq_o, wdt_rst_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    wdog_dual_ovf #(.PRE_W(4)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .irq_o(irq_o), .wdt_rst_o(wdt_rst_o)
    );

    task automatic chk(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic rd_chk(string req, logic [AW-1:0] a, logic [DW-1:0] exp);
        rd_addr = a;
        #1;
        chk(req, rd_data, exp);
    endtask

    task automatic wr(logic [AW-1:0] a, logic [DW-1:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_n(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        wait_n(3);
        rst_n = 1'b1;
    endtask

    initial begin
        wait_n(3);
        rst_n = 1'b1;
        // R1 reset state
        rd_chk("R1 ctrl", A_CTRL, 32'h0);
        rd_chk("R1 tout", A_TOUT, 32'h0);
        rd_chk("R1 elapsed", A_ELAP, 32'h0);
        rd_chk("R1 int", A_INT, 32'h0);
        rd_chk("R1 route", A_ROUTE, 32'h1);
        chk("R1 irq", {31'b0, irq_o}, 32'h0);
        chk("R1 rst", {31'b0, wdt_rst_o}, 32'h0);

        // R2, R9, R10 readback table
        for (int i = 0; i < NV; i++) begin
            wr(V_ADDR[i], V_DATA[i]);
            wait_n(6);
            rd_chk("R2/R9/R10 table", V_ADDR[i], V_EXP[i]);
            chk("R9/R10 no reset", {31'b0, wdt_rst_o}, 32'h0);
        end
        rd_chk("R10 ctrl untouched", A_CTRL, 32'h0);

        // R3 settle latency
        wr(A_TOUT, 32'h00200000);
        wait_n(5);
        rd_chk("R3 before commit", A_TOUT, 32'hFFF00000);
        wait_n(1);
        rd_chk("R3 at commit", A_TOUT, 32'h00200000);

        // R4 first overflow: T=2, step 16 -> 48 cycles after commit
        wr(A_CTRL, 32'h1);
        wait_n(53);
        chk("R4 irq before overflow", {31'b0, irq_o}, 32'h0);
        wait_n(1);
        chk("R4 irq at overflow", {31'b0, irq_o}, 32'h1);
        rd_chk("R4 int reg", A_INT, 32'h1);

        // R6 refresh
        wr(A_INT, 32'h1);
        chk("R6 irq cleared", {31'b0, irq_o}, 32'h0);
        rd_chk("R6 elapsed cleared", A_ELAP, 32'h0);
        wait_n(20);
        rd_chk("R8 elapsed one step", A_ELAP, 32'h1);
        wait_n(20);
        rd_chk("R8 elapsed two steps", A_ELAP, 32'h2);
        wait_n(7);
        chk("R6 restart before", {31'b0, irq_o}, 32'h0);
        wait_n(1);
        chk("R6 restart after", {31'b0, irq_o}, 32'h1);
        wr(A_INT, 32'hFFFFFFFE);
        chk("R6 bit0 clear ignored", {31'b0, irq_o}, 32'h1);
        wr(A_INT, 32'h1);
        chk("R6 second refresh", {31'b0, irq_o}, 32'h0);

        // R7 enable sticky
        wr(A_CTRL, 32'h0);
        wait_n(6);
        rd_chk("R7 ctrl still set", A_CTRL, 32'h1);

        // R8 elapsed restart
        wait_n(23);
        wr(A_ELAP, 32'h0);
        wait_n(6);
        rd_chk("R8 elapsed restarted", A_ELAP, 32'h0);
        wait_n(47);
        chk("R8 period moved before", {31'b0, irq_o}, 32'h0);
        wait_n(1);
        chk("R8 period moved after", {31'b0, irq_o}, 32'h1);

        // R5 second overflow
        wait_n(47);
        chk("R5 no reset yet", {31'b0, wdt_rst_o}, 32'h0);
        wait_n(1);
        chk("R5 reset asserted", {31'b0, wdt_rst_o}, 32'h1);
        wait_n(50);
        chk("R5 reset held", {31'b0, wdt_rst_o}, 32'h1);
        wr(A_INT, 32'h1);
        wait_n(2);
        chk("R5 refresh cannot clear", {31'b0, wdt_rst_o}, 32'h1);

        // R9 forced parity path
        do_reset();
        chk("R5 cleared by rst_n", {31'b0, wdt_rst_o}, 32'h0);
        wr(A_ROUTE, 32'h0);
        wait_n(6);
        wr(A_FORCE, 32'h1);
        wait_n(5);
        chk("R9 before commit", {31'b0, wdt_rst_o}, 32'h0);
        wait_n(1);
        chk("R9 forced reset", {31'b0, wdt_rst_o}, 32'h1);
        rd_chk("R10 force reads zero", A_FORCE, 32'h0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog timeout actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule